// File: doc/BRIEF.md
# Interrupt destination bitmask resolver

This block converts an inter-processor interrupt command into the set of local interrupt controllers, called agents here, that should receive it. Each of the N agents has three configuration inputs: an 8-bit physical ID, an 8-bit logical address and a 4-bit addressing model. The sender first writes the high command word, which carries the destination. It then writes the low command word, which carries the vector, delivery mode, addressing mode, level, trigger and shorthand. Writing the low word starts one resolution. The resolution combines the destination, the shorthand, the sender's own index and the agent configuration into a registered N-bit target mask, in which bit i stands for agent i.

In lowest-priority delivery the mask collapses to a single agent, the lowest-indexed candidate. An INIT command that is a level de-assert delivers no interrupt. It instead raises a one-cycle strobe that tells every targeted agent to reload its arbitration ID. The receiving logic uses the target mask together with the vector, delivery mode and trigger that are returned alongside it.

Top module: `irq_dest_resolver`

## Requirements
- R1: After reset, res_valid, arb_upd_valid, res_mask and arb_upd_mask are all zero.
- R2: A write with cmd_lo_wr high is captured at one clock edge, and its result appears after the following edge as a res_valid pulse lasting one cycle. res_valid stays low after the capture edge itself. A write with cmd_hi_wr high stores the destination from cmd_wdata[31:24] and produces no result.
- R3: With physical addressing (low word bit 11 = 0) and shorthand 0, destination 0xFF targets every agent.
- R4: With physical addressing and shorthand 0, any other destination targets only the lowest-indexed agent whose physical ID equals it. If no agent has that ID, the mask is empty.
- R5: With logical addressing (bit 11 = 1), an agent whose model is 0xF matches when the bitwise AND of the destination and its logical address is nonzero.
- R6: With logical addressing, an agent whose model is 0x0 matches when the upper nibbles of the destination and its logical address are equal and their lower nibbles share a set bit. An agent with any other model never matches.
- R7: Shorthand 1 (low word bits 19:18) targets only the agent at sender_idx, whatever the destination.
- R8: Shorthand 2 targets every agent. Shorthand 3 targets every agent except the one at sender_idx.
- R9: With delivery mode 3'b001 (bits 10:8), only the lowest-indexed set bit of the resolved mask is kept. An empty mask stays empty and res_valid still pulses.
- R10: Delivery mode 3'b101 with level (bit 14) = 0 and trigger (bit 15) = 1 is a de-assert. For it, res_valid stays low, arb_upd_valid pulses instead in the same cycle, and arb_upd_mask holds the resolved targets. An INIT command with level 1 is delivered normally.
- R11: With each result, res_vector carries bits 7:0 of the low word, res_dlv_mode carries bits 10:8 and res_trigger carries bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_hi_wr | input | 1 | Write strobe for the high command word |
| cmd_lo_wr | input | 1 | Write strobe for the low command word; starts a resolution |
| cmd_wdata | input | 32 | Command word data |
| sender_idx | input | IDX_W | Index of the sending agent, captured with the low word |
| agent_phys_id | input | 8*N_AGENTS | Physical IDs, agent i in bits 8i+7:8i |
| agent_log_dest | input | 8*N_AGENTS | Logical addresses, agent i in bits 8i+7:8i |
| agent_model | input | 4*N_AGENTS | Addressing models, agent i in bits 4i+3:4i |
| res_valid | output | 1 | One-cycle pulse: delivery result is valid |
| res_mask | output | N_AGENTS | Target agents of the delivery |
| res_vector | output | 8 | Vector of the command |
| res_dlv_mode | output | 3 | Delivery mode of the command |
| res_trigger | output | 1 | Trigger mode of the command |
| arb_upd_valid | output | 1 | One-cycle pulse: arbitration-ID reload request |
| arb_upd_mask | output | N_AGENTS | Agents that reload their arbitration ID |

## Verification
The bench builds the block with N_AGENTS = 6 and PICK_ARITH = 0. The agent count is not a power of two, so sender_idx has spare codes and the all-but-self mask must leave unused bits clear. The ripple form of the lowest-bit picker is the one exercised. The six agents mix flat, cluster and unmatched models, and two agents share a physical ID. With that set-up, a single destination can hit agents in different models, clusters with equal upper nibbles but disjoint lower nibbles can be shown to miss, and the rule that a duplicate ID goes to the lowest index can be observed.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;

   localparam int DEST_W  = 8;
   localparam int MODEL_W = 4;
   localparam int WORD_W  = 32;

   localparam logic [MODEL_W-1:0] MODEL_FLAT    = 4'hF;
   localparam logic [MODEL_W-1:0] MODEL_CLUSTER = 4'h0;

   localparam logic [DEST_W-1:0] DEST_BCAST = 8'hFF;

   typedef enum logic [2:0] {
      DLV_FIXED   = 3'd0,
      DLV_LOWPRI  = 3'd1,
      DLV_SMI     = 3'd2,
      DLV_RSVD    = 3'd3,
      DLV_NMI     = 3'd4,
      DLV_INIT    = 3'd5,
      DLV_STARTUP = 3'd6,
      DLV_EXTINT  = 3'd7
   } dlv_mode_e;

   typedef enum logic [1:0] {
      SH_NONE     = 2'd0,
      SH_SELF     = 2'd1,
      SH_ALL      = 2'd2,
      SH_ALL_BUT  = 2'd3
   } shorthand_e;

   typedef struct packed {
      logic [7:0] vector;
      dlv_mode_e  mode;
      logic       logical;
      logic       level;
      logic       trigger;
      shorthand_e shorthand;
   } cmd_fields_t;

endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
   import irq_dest_pkg::*;
(
   input  logic [WORD_W-1:0] lo_word,
   output cmd_fields_t       fields,
   output logic              is_deassert
);

   logic unused_bits;
   assign unused_bits = ^{lo_word[31:20], lo_word[17:16], lo_word[13:12]};

   always_comb begin
      fields.vector    = lo_word[7:0];
      fields.mode      = dlv_mode_e'(lo_word[10:8]);
      fields.logical   = lo_word[11];
      fields.level     = lo_word[14];
      fields.trigger   = lo_word[15];
      fields.shorthand = shorthand_e'(lo_word[19:18]);
   end

   assign is_deassert = (fields.mode == DLV_INIT) && !fields.level && fields.trigger;

endmodule

// File: rtl/irq_agent_match.sv
module irq_agent_match
   import irq_dest_pkg::*;
(
   input  logic [DEST_W-1:0]  dest,
   input  logic [DEST_W-1:0]  phys_id,
   input  logic [DEST_W-1:0]  log_addr,
   input  logic [MODEL_W-1:0] model,
   output logic               id_hit,
   output logic               log_hit
);

   logic flat_hit;
   logic clus_hit;

   assign id_hit   = (dest == phys_id);
   assign flat_hit = |(dest & log_addr);
   assign clus_hit = (dest[7:4] == log_addr[7:4]) && |(dest[3:0] & log_addr[3:0]);

   always_comb begin
      unique case (model)
         MODEL_FLAT:    log_hit = flat_hit;
         MODEL_CLUSTER: log_hit = clus_hit;
         default:       log_hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
   parameter int WIDTH      = 8,
   parameter bit PICK_ARITH = 1'b1
) (
   input  logic [WIDTH-1:0] req,
   output logic [WIDTH-1:0] pick
);

   generate
      if (PICK_ARITH) begin : g_arith
         assign pick = req & (~req + WIDTH'(1));
      end else begin : g_ripple
         logic [WIDTH:0] seen;
         assign seen[0] = 1'b0;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign pick[i]   = req[i] & ~seen[i];
            assign seen[i+1] = seen[i] | req[i];
         end
      end
   endgenerate

endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
   import irq_dest_pkg::*;
#(
   parameter int  N_AGENTS   = 8,
   parameter bit  PICK_ARITH = 1'b1,
   localparam int IDX_W      = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cmd_hi_wr,
   input  logic                        cmd_lo_wr,
   input  logic [WORD_W-1:0]           cmd_wdata,
   input  logic [IDX_W-1:0]            sender_idx,
   input  logic [N_AGENTS*DEST_W-1:0]  agent_phys_id,
   input  logic [N_AGENTS*DEST_W-1:0]  agent_log_dest,
   input  logic [N_AGENTS*MODEL_W-1:0] agent_model,
   output logic                        res_valid,
   output logic [N_AGENTS-1:0]         res_mask,
   output logic [7:0]                  res_vector,
   output logic [2:0]                  res_dlv_mode,
   output logic                        res_trigger,
   output logic                        arb_upd_valid,
   output logic [N_AGENTS-1:0]         arb_upd_mask
);

   localparam logic [N_AGENTS-1:0] ALL_ONES = {N_AGENTS{1'b1}};

   generate
      if (N_AGENTS < 1 || N_AGENTS > 256) begin : g_bad_count
         $error("irq_dest_resolver: N_AGENTS must lie in 1..256");
      end
   endgenerate

   // capture stage
   cmd_fields_t        dec_fields;
   logic               dec_deassert;
   cmd_fields_t        cmd_q;
   logic               deassert_q;
   logic               go_q;
   logic [IDX_W-1:0]   sender_q;
   logic [DEST_W-1:0]  dest_q;

   irq_cmd_decode u_decode (
      .lo_word     (cmd_wdata),
      .fields      (dec_fields),
      .is_deassert (dec_deassert)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         go_q       <= 1'b0;
         cmd_q      <= '0;
         deassert_q <= 1'b0;
         sender_q   <= '0;
         dest_q     <= '0;
      end else begin
         go_q <= cmd_lo_wr;
         if (cmd_hi_wr) begin
            dest_q <= cmd_wdata[31:24];
         end
         if (cmd_lo_wr) begin
            cmd_q      <= dec_fields;
            deassert_q <= dec_deassert;
            sender_q   <= sender_idx;
         end
      end
   end

   // resolve stage
   logic [N_AGENTS-1:0] id_hits;
   logic [N_AGENTS-1:0] log_hits;
   logic [N_AGENTS-1:0] self_mask;

   for (genvar i = 0; i < N_AGENTS; i++) begin : g_agent
      irq_agent_match u_match (
         .dest     (dest_q),
         .phys_id  (agent_phys_id[i*DEST_W +: DEST_W]),
         .log_addr (agent_log_dest[i*DEST_W +: DEST_W]),
         .model    (agent_model[i*MODEL_W +: MODEL_W]),
         .id_hit   (id_hits[i]),
         .log_hit  (log_hits[i])
      );
      assign self_mask[i] = (sender_q == IDX_W'(i));
   end

   logic [N_AGENTS-1:0] id_first;
   logic [N_AGENTS-1:0] dest_mask;
   logic [N_AGENTS-1:0] shaped_mask;
   logic [N_AGENTS-1:0] lowest_mask;
   logic [N_AGENTS-1:0] final_mask;

   irq_lowest_pick #(.WIDTH(N_AGENTS), .PICK_ARITH(PICK_ARITH)) u_id_pick (
      .req  (id_hits),
      .pick (id_first)
   );

   always_comb begin
      if (cmd_q.logical) begin
         dest_mask = log_hits;
      end else if (dest_q == DEST_BCAST) begin
         dest_mask = ALL_ONES;
      end else begin
         dest_mask = id_first;
      end
   end

   always_comb begin
      unique case (cmd_q.shorthand)
         SH_NONE:    shaped_mask = dest_mask;
         SH_SELF:    shaped_mask = self_mask;
         SH_ALL:     shaped_mask = ALL_ONES;
         SH_ALL_BUT: shaped_mask = ~self_mask;
         default:    shaped_mask = '0;
      endcase
   end

   irq_lowest_pick #(.WIDTH(N_AGENTS), .PICK_ARITH(PICK_ARITH)) u_lp_pick (
      .req  (shaped_mask),
      .pick (lowest_mask)
   );

   assign final_mask = (cmd_q.mode == DLV_LOWPRI) ? lowest_mask : shaped_mask;

   // result registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid     <= 1'b0;
         res_mask      <= '0;
         res_vector    <= '0;
         res_dlv_mode  <= '0;
         res_trigger   <= 1'b0;
         arb_upd_valid <= 1'b0;
         arb_upd_mask  <= '0;
      end else begin
         res_valid     <= go_q && !deassert_q;
         arb_upd_valid <= go_q && deassert_q;
         if (go_q && !deassert_q) begin
            res_mask     <= final_mask;
            res_vector   <= cmd_q.vector;
            res_dlv_mode <= cmd_q.mode;
            res_trigger  <= cmd_q.trigger;
         end
         if (go_q && deassert_q) begin
            arb_upd_mask <= shaped_mask;
         end
      end
   end

endmodule

// File: rtl/irq_dest_resolver_chk.sv
module irq_dest_resolver_chk #(
   parameter int N_AGENTS = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cmd_lo_wr,
   input logic [1:0]          lo_sh,
   input logic [2:0]          lo_mode,
   input logic                res_valid,
   input logic [N_AGENTS-1:0] res_mask,
   input logic [2:0]          res_dlv_mode,
   input logic                arb_upd_valid
);

   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(cmd_lo_wr, 2))
      else $error("p_latency_r2");

   p_lowpri_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_dlv_mode == 3'd1) |-> $onehot0(res_mask))
      else $error("p_lowpri_single_r9");

   p_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_dlv_mode != 3'd1 && $past(cmd_lo_wr && lo_sh == 2'd2, 2))
         |-> (&res_mask))
      else $error("p_all_r8");

   p_self_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && $past(cmd_lo_wr && lo_sh == 2'd1, 2)) |-> ($countones(res_mask) <= 1))
      else $error("p_self_r7");

   p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      arb_upd_valid |-> !res_valid)
      else $error("p_excl_r10");

   p_init_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      arb_upd_valid |-> $past(cmd_lo_wr && lo_mode == 3'd5, 2))
      else $error("p_init_src_r10");

endmodule

bind irq_dest_resolver irq_dest_resolver_chk #(.N_AGENTS(N_AGENTS)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_lo_wr     (cmd_lo_wr),
   .lo_sh         (cmd_wdata[19:18]),
   .lo_mode       (cmd_wdata[10:8]),
   .res_valid     (res_valid),
   .res_mask      (res_mask),
   .res_dlv_mode  (res_dlv_mode),
   .arb_upd_valid (arb_upd_valid)
);

// File: tb/irq_dest_resolver_tb_top.sv
module irq_dest_resolver_tb_top;

   localparam int N     = 6;
   localparam int IDX_W = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cmd_hi_wr = 1'b0;
   logic             cmd_lo_wr = 1'b0;
   logic [31:0]      cmd_wdata = '0;
   logic [IDX_W-1:0] sender_idx = '0;
   logic [N*8-1:0]   agent_phys_id;
   logic [N*8-1:0]   agent_log_dest;
   logic [N*4-1:0]   agent_model;
   logic             res_valid;
   logic [N-1:0]     res_mask;
   logic [7:0]       res_vector;
   logic [2:0]       res_dlv_mode;
   logic             res_trigger;
   logic             arb_upd_valid;
   logic [N-1:0]     arb_upd_mask;

   int checks = 0;
   int errors = 0;
   logic early_valid;

   always #10 clk = ~clk;

   // agents: 0 flat 0x01, 1 flat 0x02, 2 cluster 0x31, 3 cluster 0x32,
   //         4 model 5 (never), 5 cluster 0x41; IDs 10 21 32 21 05 07
   assign agent_phys_id  = {8'h07, 8'h05, 8'h21, 8'h32, 8'h21, 8'h10};
   assign agent_log_dest = {8'h41, 8'hFF, 8'h32, 8'h31, 8'h02, 8'h01};
   assign agent_model    = {4'h0, 4'h5, 4'h0, 4'h0, 4'hF, 4'hF};

   irq_dest_resolver #(.N_AGENTS(N), .PICK_ARITH(1'b0)) dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .cmd_hi_wr      (cmd_hi_wr),
      .cmd_lo_wr      (cmd_lo_wr),
      .cmd_wdata      (cmd_wdata),
      .sender_idx     (sender_idx),
      .agent_phys_id  (agent_phys_id),
      .agent_log_dest (agent_log_dest),
      .agent_model    (agent_model),
      .res_valid      (res_valid),
      .res_mask       (res_mask),
      .res_vector     (res_vector),
      .res_dlv_mode   (res_dlv_mode),
      .res_trigger    (res_trigger),
      .arb_upd_valid  (arb_upd_valid),
      .arb_upd_mask   (arb_upd_mask)
   );

   function automatic logic [31:0] mk_lo(input logic [7:0] vec, input logic [2:0] mode,
                                         input logic logical, input logic level,
                                         input logic trig, input logic [1:0] sh);
      return {12'b0, sh, 2'b0, trig, level, 2'b0, logical, mode, vec};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic write_hi(input logic [7:0] dest);
      @(negedge clk);
      cmd_hi_wr = 1'b1;
      cmd_wdata = {dest, 24'h0};
      @(negedge clk);
      cmd_hi_wr = 1'b0;
      cmd_wdata = '0;
   endtask

   task automatic issue(input logic [31:0] lo, input int snd);
      @(negedge clk);
      cmd_lo_wr  = 1'b1;
      cmd_wdata  = lo;
      sender_idx = IDX_W'(snd);
      @(negedge clk);
      cmd_lo_wr  = 1'b0;
      cmd_wdata  = '0;
      early_valid = res_valid;
      @(negedge clk);
   endtask

   task automatic resolve(input string req, input logic [7:0] dest, input logic [31:0] lo,
                          input int snd, input logic [N-1:0] exp);
      write_hi(dest);
      issue(lo, snd);
      chk(req, "valid", 32'(res_valid), 32'd1);
      chk(req, "mask", 32'(res_mask), 32'(exp));
   endtask

   task automatic t_reset();
      chk("R1", "res_valid", 32'(res_valid), 0);
      chk("R1", "arb_upd_valid", 32'(arb_upd_valid), 0);
      chk("R1", "res_mask", 32'(res_mask), 0);
      chk("R1", "arb_upd_mask", 32'(arb_upd_mask), 0);
   endtask

   task automatic t_timing();
      write_hi(8'hFF);
      chk("R2", "no result on high write", 32'(res_valid), 0);
      @(negedge clk);
      chk("R2", "no result on high write later", 32'(res_valid), 0);
      issue(mk_lo(8'h40, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0), 0);
      chk("R2", "valid low after capture edge", 32'(early_valid), 0);
      chk("R2", "valid one cycle later", 32'(res_valid), 1);
      @(negedge clk);
      chk("R2", "valid single cycle", 32'(res_valid), 0);
   endtask

   task automatic t_physical();
      resolve("R3", 8'hFF, mk_lo(8'h30, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0), 0, 6'b111111);
      resolve("R4", 8'h21, mk_lo(8'h30, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0), 0, 6'b000010);
      resolve("R4", 8'h05, mk_lo(8'h30, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0), 0, 6'b010000);
      resolve("R4", 8'h99, mk_lo(8'h30, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0), 0, 6'b000000);
   endtask

   task automatic t_logical();
      resolve("R5", 8'h03, mk_lo(8'h31, 3'd0, 1'b1, 1'b0, 1'b0, 2'd0), 0, 6'b000011);
      resolve("R6", 8'h32, mk_lo(8'h31, 3'd0, 1'b1, 1'b0, 1'b0, 2'd0), 0, 6'b001010);
      resolve("R6", 8'hFF, mk_lo(8'h31, 3'd0, 1'b1, 1'b0, 1'b0, 2'd0), 0, 6'b000011);
      resolve("R6", 8'h41, mk_lo(8'h31, 3'd0, 1'b1, 1'b0, 1'b0, 2'd0), 0, 6'b100001);
   endtask

   task automatic t_shorthand();
      resolve("R7", 8'hFF, mk_lo(8'h50, 3'd0, 1'b0, 1'b0, 1'b0, 2'd1), 4, 6'b010000);
      resolve("R8", 8'h99, mk_lo(8'h50, 3'd0, 1'b0, 1'b0, 1'b0, 2'd2), 2, 6'b111111);
      resolve("R8", 8'h99, mk_lo(8'h50, 3'd0, 1'b0, 1'b0, 1'b0, 2'd3), 2, 6'b111011);
   endtask

   task automatic t_lowpri();
      resolve("R9", 8'h32, mk_lo(8'h60, 3'd1, 1'b1, 1'b0, 1'b0, 2'd0), 0, 6'b000010);
      resolve("R9", 8'h99, mk_lo(8'h60, 3'd1, 1'b0, 1'b0, 1'b0, 2'd3), 0, 6'b000010);
      resolve("R9", 8'h99, mk_lo(8'h60, 3'd1, 1'b0, 1'b0, 1'b0, 2'd0), 0, 6'b000000);
   endtask

   task automatic t_init();
      write_hi(8'h10);
      issue(mk_lo(8'h00, 3'd5, 1'b0, 1'b0, 1'b1, 2'd2), 1);
      chk("R10", "deassert res_valid", 32'(res_valid), 0);
      chk("R10", "deassert arb_upd_valid", 32'(arb_upd_valid), 1);
      chk("R10", "deassert arb_upd_mask", 32'(arb_upd_mask), 32'h3F);
      @(negedge clk);
      chk("R10", "arb_upd_valid single cycle", 32'(arb_upd_valid), 0);
      issue(mk_lo(8'h00, 3'd5, 1'b0, 1'b1, 1'b1, 2'd0), 1);
      chk("R10", "asserted INIT res_valid", 32'(res_valid), 1);
      chk("R10", "asserted INIT arb_upd_valid", 32'(arb_upd_valid), 0);
      chk("R10", "asserted INIT mask", 32'(res_mask), 32'h01);
   endtask

   task automatic t_fields();
      resolve("R11", 8'hFF, mk_lo(8'hA7, 3'd4, 1'b0, 1'b1, 1'b1, 2'd0), 0, 6'b111111);
      chk("R11", "vector", 32'(res_vector), 32'hA7);
      chk("R11", "mode", 32'(res_dlv_mode), 32'd4);
      chk("R11", "trigger", 32'(res_trigger), 32'd1);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_timing();
            t_physical();
            t_logical();
            t_shorthand();
            t_lowpri();
            t_init();
            t_fields();
         end
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual=hung expected=complete");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule